// File: doc/BRIEF.md
# Timestamp Capture FIFO

This block records hardware timestamps for precision-time event frames travelling in one direction. A frame-detect strobe comes from an external parser. On that strobe the block takes the current time-of-day value and the frame's 16-bit sequence number on the same clock edge. It stores all three as one entry in a small first-in first-out queue.

Software reads the oldest entry through a set of 16-bit register words, one word per read:

- the upper nanoseconds, which also carry a valid flag;
- the lower nanoseconds;
- the two halves of the seconds;
- the sequence number.

Reading the sequence-number word removes the entry. Other registers give the number of pending entries and two sticky event flags, one for "entry captured" and one for "capture lost to a full queue". The event flags clear when they are read. A maskable interrupt line is driven from them.

Frame classification and the time counter sit outside the block and arrive as inputs.

Top module: `ts_capture_fifo`

## Requirements
- R1: After reset the queue is empty, the count register (address 5) reads 0, the event register (address 6) reads 0, and `irq` is low.
- R2: A strobe captures `tod_ns`, `tod_sec` and `frame_seq` from the same clock edge. The entry reads back as follows:
  - address 0 bits [13:0]: nanoseconds [29:16]
  - address 1: nanoseconds [15:0]
  - address 2: seconds [31:16]
  - address 3: seconds [15:0]
  - address 4: sequence number
- R3: Bit 15 of address 0 is the valid flag. It is 1 exactly when the queue holds an entry. Bit 14 of address 0 always reads 0.
- R4: A read strobe on address 4 removes the oldest entry, and entries come out in capture order. Reads of addresses 0 to 3 and 5 remove nothing.
- R5: Address 5 returns the number of stored entries, from 0 to DEPTH (default 8).
- R6: Bit 0 of address 6 (the available flag) is set by every accepted capture and stays set until it is cleared by R8.
- R7: A strobe that finds the queue full, with no removal in the same cycle, sets bit 1 of address 6 (overflow). That capture is dropped, and the stored entries and the count are unchanged.
- R8: A read strobe on address 6 returns the flags and then clears them. A flag that is set in that same cycle stays set.
- R9: `irq` is high exactly when some flag in address 6 is set and its bit in `irq_en` is 1.
- R10: A strobe together with a removal on a full queue stores the new entry, removes the oldest one, keeps the count at DEPTH and does not set overflow.
- R11: A read strobe on address 4 while the queue is empty changes nothing; the queue stays empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_strobe | input | 1 | Frame-detect strobe; one cycle per event frame |
| tod_sec | input | 32 | Current time of day, seconds |
| tod_ns | input | 30 | Current time of day, nanoseconds |
| frame_seq | input | 16 | Sequence number of the detected frame |
| rd_en | input | 1 | Read strobe; triggers a read's side effects |
| rd_addr | input | 3 | Register word address |
| rd_data | output | 16 | Word at `rd_addr` (combinational) |
| irq_en | input | 2 | Per-flag interrupt enables: bit 0 available, bit 1 overflow |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `cap_strobe`, `rd_en` and `rd_addr` change only between clock edges. They also assume that a single read strobe targets one address, so a removal and a flag clear never coincide. The bench drives every input at the falling edge and issues one read per cycle. It samples the combinational `rd_data` before the next rising edge, so each read returns the pre-edge state that the properties reason about. Captures are combined with removals and flag reads in the same cycle only in the directed cases that R8 and R10 describe.

// File: rtl/ts_capture_fifo.sv
module ts_capture_fifo #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_strobe,
  input  logic [31:0] tod_sec,
  input  logic [29:0] tod_ns,
  input  logic [15:0] frame_seq,
  input  logic        rd_en,
  input  logic [2:0]  rd_addr,
  output logic [15:0] rd_data,
  input  logic [1:0]  irq_en,
  output logic        irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [2:0] A_NSH = 3'd0, A_NSL = 3'd1, A_SCH = 3'd2, A_SCL = 3'd3;
  localparam logic [2:0] A_SEQ = 3'd4, A_CNT = 3'd5, A_STS = 3'd6;

  logic [29:0] ns_q  [DEPTH];
  logic [31:0] sec_q [DEPTH];
  logic [15:0] seq_q [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic flag_av, flag_ov;

  wire empty  = (count == '0);
  wire full   = (count == CW'(DEPTH));
  wire pop    = rd_en && (rd_addr == A_SEQ) && !empty;
  wire push   = cap_strobe && (!full || pop);
  wire drop   = cap_strobe && full && !pop;
  wire sts_rd = rd_en && (rd_addr == A_STS);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      ns_q[wr_ptr]  <= tod_ns;
      sec_q[wr_ptr] <= tod_sec;
      seq_q[wr_ptr] <= frame_seq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      flag_av <= 1'b0;
      flag_ov <= 1'b0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
      flag_av <= push || (flag_av && !sts_rd);
      flag_ov <= drop || (flag_ov && !sts_rd);
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_NSH: rd_data = {!empty, 1'b0, ns_q[rd_ptr][29:16]};
      A_NSL: rd_data = ns_q[rd_ptr][15:0];
      A_SCH: rd_data = sec_q[rd_ptr][31:16];
      A_SCL: rd_data = sec_q[rd_ptr][15:0];
      A_SEQ: rd_data = seq_q[rd_ptr];
      A_CNT: rd_data = 16'(count);
      A_STS: rd_data = {14'd0, flag_ov, flag_av};
      default: rd_data = '0;
    endcase
  end

  assign irq = |({flag_ov, flag_av} & irq_en);

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r7_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_strobe && count == CW'(DEPTH) && !(rd_en && rd_addr == A_SEQ)) |=> flag_ov);
  a_r7_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_strobe && count == CW'(DEPTH) && !(rd_en && rd_addr == A_SEQ)) |=> count == $past(count));
  a_r10_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_strobe && count == CW'(DEPTH) && rd_en && rd_addr == A_SEQ)
      |=> (count == CW'(DEPTH)) && (flag_ov == $past(flag_ov)));
  a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_SEQ && count == '0 && !cap_strobe) |=> count == '0);
  a_r3_valid_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_NSH) |-> (rd_data[15] == (count != '0)) && !rd_data[14]);
  a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_STS && !cap_strobe) |=> !flag_av && !flag_ov);
  a_r6_avail_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_strobe && count != CW'(DEPTH)) |=> flag_av);
endmodule

// File: tb/test_ts_capture_fifo.sv
module test_ts_capture_fifo;
  logic clk = 0, rst_n = 0, cap_strobe = 0, rd_en = 0, irq;
  logic [31:0] tod_sec = 0;
  logic [29:0] tod_ns = 0;
  logic [15:0] frame_seq = 0, rd_data, d;
  logic [2:0] rd_addr = 0;
  logic [1:0] irq_en = 0;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  ts_capture_fifo #(.DEPTH(8)) i_ts_capture_fifo (
    .clk(clk), .rst_n(rst_n), .cap_strobe(cap_strobe), .tod_sec(tod_sec),
    .tod_ns(tod_ns), .frame_seq(frame_seq), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_en(irq_en), .irq(irq));

  function automatic logic [29:0] e_ns(input int k);
    return 30'((k * 32'd12345679 + 7) & 32'h3FFF_FFFF);
  endfunction
  function automatic logic [31:0] e_sec(input int k);
    return 32'h1000_0000 + k * 32'd7919 + (k << 20);
  endfunction
  function automatic logic [15:0] e_seq(input int k);
    return 16'hA000 + 16'(k * 3);
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic tick(input logic cs, input int k, input logic re,
                      input logic [2:0] a, output logic [15:0] q);
    cap_strobe = cs; tod_sec = e_sec(k); tod_ns = e_ns(k); frame_seq = e_seq(k);
    rd_en = re; rd_addr = a;
    #1 q = rd_data;
    @(posedge clk); @(negedge clk);
    cap_strobe = 0; rd_en = 0;
  endtask

  task automatic drain_one(input int k, input string r);
    logic [15:0] q;
    logic [29:0] n = e_ns(k);
    logic [31:0] s = e_sec(k);
    tick(0, 0, 1, 3'd0, q); chk({r, " R2 R3 ns_hi"}, q, {1'b1, 1'b0, n[29:16]});
    tick(0, 0, 1, 3'd1, q); chk({r, " R2 ns_lo"}, q, n[15:0]);
    tick(0, 0, 1, 3'd2, q); chk({r, " R2 sec_hi"}, q, s[31:16]);
    tick(0, 0, 1, 3'd3, q); chk({r, " R2 sec_lo"}, q, s[15:0]);
    tick(0, 0, 1, 3'd4, q); chk({r, " R4 seq order"}, q, e_seq(k));
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick(0, 0, 0, 3'd5, d); chk("R1 count", d, 0);
    tick(0, 0, 0, 3'd6, d); chk("R1 flags", d, 0);
    chk("R1 irq", irq, 0);
    tick(0, 0, 0, 3'd0, d); chk("R1 R3 valid empty", d[15], 0);

    tick(0, 0, 1, 3'd4, d);
    tick(0, 0, 0, 3'd5, d); chk("R11 empty pop count", d, 0);
    tick(0, 0, 0, 3'd6, d); chk("R11 no flags", d, 0);

    for (int k = 0; k < 8; k++) begin
      tick(1, k, 0, 3'd5, d);
      tick(0, 0, 0, 3'd5, d); chk("R5 count fill", d, k + 1);
    end
    tick(0, 0, 0, 3'd6, d); chk("R6 avail set", d, 1);
    chk("R9 irq masked", irq, 0);
    irq_en = 2'b01; #1 chk("R9 irq avail", irq, 1);
    irq_en = 2'b10; #1 chk("R9 irq ovf mask", irq, 0);
    tick(0, 0, 1, 3'd0, d); tick(0, 0, 1, 3'd1, d); tick(0, 0, 1, 3'd5, d);
    tick(0, 0, 0, 3'd5, d); chk("R4 non-seq reads keep", d, 8);

    tick(1, 99, 0, 3'd5, d);
    tick(0, 0, 0, 3'd5, d); chk("R7 count held", d, 8);
    chk("R9 irq ovf", irq, 1);
    tick(0, 0, 1, 3'd6, d); chk("R7 R8 flags read", d, 3);
    tick(0, 0, 1, 3'd6, d); chk("R8 cleared", d, 0);
    chk("R9 irq low", irq, 0);

    for (int k = 0; k < 8; k++) begin
      drain_one(k, "drain1");
      tick(0, 0, 0, 3'd5, d); chk("R5 count drain", d, 7 - k);
    end
    tick(0, 0, 0, 3'd0, d); chk("R7 dropped R3 valid", d[15], 0);

    for (int k = 10; k < 18; k++) tick(1, k, 0, 3'd5, d);
    tick(0, 0, 1, 3'd6, d); chk("R6 refill flags", d, 1);
    tick(1, 18, 1, 3'd4, d); chk("R10 popped head", d, e_seq(10));
    tick(0, 0, 0, 3'd5, d); chk("R10 count full", d, 8);
    tick(0, 0, 1, 3'd6, d); chk("R10 no overflow", d, 1);
    for (int k = 11; k < 19; k++) drain_one(k, "drain2 R10");
    tick(0, 0, 0, 3'd5, d); chk("R5 empty", d, 0);

    tick(1, 20, 1, 3'd6, d); chk("R8 read before set", d, 0);
    tick(0, 0, 1, 3'd6, d); chk("R8 set wins", d, 1);
    tick(0, 0, 0, 3'd5, d); chk("R5 one entry", d, 1);
    drain_one(20, "single");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule